// File: doc/BRIEF.md
# Nth-Chance Page Reclaim Sweeper

This block picks a physical page frame to reclaim. It keeps, for each of a fixed set of frames, a use flag and a small age counter. The age counter holds the number of sweeps the frame has seen since it was last used. An access port sets a frame's use flag. When a page fault needs a frame, the requester pulses `req`. A circular hand then visits one frame per clock.

- If the frame was used since the last visit, the hand clears its use flag and sets its age back to zero.
- If the frame is unused and its age is below the limit, the hand adds one to its age.
- If the frame is unused and its age has reached the limit, that frame becomes the victim. The hand stops on it and reports it.

With a limit of zero this is the basic clock scheme: the first unused frame is taken. Larger limits make recency more precise, at the cost of longer sweeps.

A single controller runs the search. It has three states:

- IDLE: waits for a request.
- SCAN: one frame is visited per cycle.
- DONE: the victim is presented for one cycle.

The transitions are:

- IDLE→SCAN when `req` is high.
- SCAN→SCAN while no victim is found.
- SCAN→DONE on the visit that selects a victim.
- DONE→IDLE always.

The limit is captured on the IDLE→SCAN transition. The next search starts at the frame after the last victim.

Top module: `nth_chance_sweeper`

## Requirements
- R1: After reset `done` and `busy` are 0 and `victim` is 0. Every frame is unused with age 0 and the hand points at frame 0, so a first search with limit 0 returns frame 0 after a single visit.
- R2: When the hand visits a frame whose use flag is set, the visit clears the flag, sets the frame's age to 0 and moves the hand to the next frame.
- R3: When the hand visits an unused frame whose age is below the captured limit, the visit adds one to the age and moves the hand on.
- R4: When the hand visits an unused frame whose age is equal to or above the captured limit, that frame is the victim. `done` is high for exactly one cycle, in the cycle after that visit, with `victim` carrying the frame index. `victim` holds its value at all other times.
- R5: The hand visits frames in ascending index order, one per cycle, and wraps from the last frame to frame 0. `busy` rises the cycle after an accepted request and stays high through the `done` cycle, so a search of k visits keeps `busy` high for k+1 cycles.
- R6: `limit` is sampled only when a request is accepted. Changing it during a search has no effect on that search. A limit of 0 reclaims the first unused frame the hand meets.
- R7: A cycle with `acc_valid` high sets the use flag of frame `acc_frame`. If that frame is the one the hand visits in the same cycle, the access wins: the visit treats the frame as used, sets its age to 0 and leaves the use flag set.
- R8: On selection, the victim's use flag and age are cleared, and the next search begins at the frame after the victim (wrapping).
- R9: A `req` pulse while `busy` is high is ignored and produces no extra `done`.
- R10: A search with no access during it finishes within (limit+1)*NUM_FRAMES+NUM_FRAMES visits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Marks an access to frame `acc_frame` in this cycle |
| acc_frame | input | IDX_W | Index of the accessed frame |
| req | input | 1 | Starts a victim search when the block is idle |
| limit | input | AGE_W | Number of idle sweeps a frame survives before reclaim (N) |
| done | output | 1 | One-cycle pulse: `victim` is valid |
| busy | output | 1 | A search is in progress (SCAN or DONE) |
| victim | output | IDX_W | Index of the selected frame, held between searches |

## Verification
The bench builds the block with its defaults: 16 frames and 3-bit ages. This keeps the worst-case search short, about 129 visits when every frame is marked used and the limit is 7, so it can be run in full. That case reaches the visit bound together with hand wrap-around and the 3-bit age at its maximum value.

Limits of 0, 1, 3 and 7 exercise the following:
- clock-style reclaim;
- one-step ageing over a full pass;
- ages above a lowered limit.

Two further stimuli each occur once, during a long search:
- an access landing on the frame under the hand;
- a limit change with a stray request.

// File: rtl/nth_pkg.sv
package nth_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } sweep_state_t;

    typedef enum logic [1:0] {
        OP_NONE    = 2'd0,
        OP_RENEW   = 2'd1,
        OP_AGE     = 2'd2,
        OP_RECLAIM = 2'd3
    } visit_op_t;

endpackage

// File: rtl/frame_table.sv
module frame_table
    import nth_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int AGE_W      = 3,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic [IDX_W-1:0] visit_idx,
    input  visit_op_t        op,
    output logic             vis_used,
    output logic [AGE_W-1:0] vis_age
);

    logic [NUM_FRAMES-1:0] use_vec;
    logic [AGE_W-1:0]      age_arr [NUM_FRAMES];

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        logic             use_r;
        logic [AGE_W-1:0] age_r;
        logic             hit_acc;
        logic             sel;

        assign hit_acc = acc_valid && (acc_frame == IDX_W'(g));
        assign sel     = (visit_idx == IDX_W'(g)) && (op != OP_NONE);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                use_r <= 1'b0;
                age_r <= '0;
            end else begin
                // a same-cycle access always leaves the flag set
                use_r <= hit_acc | (use_r & ~sel);
                if (sel) begin
                    unique case (op)
                        OP_AGE:  age_r <= age_r + 1'b1;
                        default: age_r <= '0;
                    endcase
                end
            end
        end

        assign use_vec[g] = use_r;
        assign age_arr[g] = age_r;
    end

    assign vis_used = use_vec[visit_idx] | (acc_valid && (acc_frame == visit_idx));
    assign vis_age  = age_arr[visit_idx];

endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
    import nth_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int AGE_W      = 3,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [AGE_W-1:0] limit,
    input  logic             vis_used,
    input  logic [AGE_W-1:0] vis_age,
    output logic [IDX_W-1:0] hand,
    output visit_op_t        op,
    output logic             done,
    output logic             busy,
    output logic [IDX_W-1:0] victim
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_FRAMES - 1);

    sweep_state_t     state_q, state_d;
    logic [AGE_W-1:0] limit_q;
    logic [IDX_W-1:0] victim_q;
    logic             found;

    // visit decision
    always_comb begin
        op    = OP_NONE;
        found = 1'b0;
        if (state_q == ST_SCAN) begin
            if (vis_used) begin
                op = OP_RENEW;
            end else if (vis_age < limit_q) begin
                op = OP_AGE;
            end else begin
                op    = OP_RECLAIM;
                found = 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)   state_d = ST_SCAN;
            ST_SCAN: if (found) state_d = ST_DONE;
            ST_DONE:            state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hand     <= '0;
            limit_q  <= '0;
            victim_q <= '0;
        end else begin
            if (state_q == ST_IDLE && req) limit_q <= limit;
            if (state_q == ST_SCAN) hand <= (hand == LAST) ? '0 : hand + 1'b1;
            if (found) victim_q <= hand;
        end
    end

    // outputs
    always_comb begin
        done   = (state_q == ST_DONE);
        busy   = (state_q != ST_IDLE);
        victim = victim_q;
    end

endmodule

// File: rtl/nth_chance_sweeper.sv
module nth_chance_sweeper
    import nth_pkg::*;
#(
    parameter int NUM_FRAMES = 16,
    parameter int AGE_W      = 3,
    localparam int IDX_W     = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             req,
    input  logic [AGE_W-1:0] limit,
    output logic             done,
    output logic             busy,
    output logic [IDX_W-1:0] victim
);

    logic [IDX_W-1:0] hand;
    visit_op_t        op;
    logic             vis_used;
    logic [AGE_W-1:0] vis_age;

    frame_table #(.NUM_FRAMES(NUM_FRAMES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_frame (acc_frame),
        .visit_idx (hand),
        .op        (op),
        .vis_used  (vis_used),
        .vis_age   (vis_age)
    );

    sweep_fsm #(.NUM_FRAMES(NUM_FRAMES), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .limit    (limit),
        .vis_used (vis_used),
        .vis_age  (vis_age),
        .hand     (hand),
        .op       (op),
        .done     (done),
        .busy     (busy),
        .victim   (victim)
    );

endmodule

// File: rtl/nth_chance_sweeper_chk.sv
module nth_chance_sweeper_chk #(
    parameter int NUM_FRAMES = 16,
    parameter int AGE_W      = 3,
    parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             req,
    input logic [AGE_W-1:0] limit,
    input logic             done,
    input logic             busy,
    input logic [IDX_W-1:0] victim
);

    localparam int CNT_W = $clog2(((1 << AGE_W) + 1) * NUM_FRAMES + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [AGE_W-1:0] lim_q;
    logic [CNT_W-1:0] visits_q;
    logic             acc_seen_q;
    logic [CNT_W-1:0] bound;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q      <= '0;
            visits_q   <= '0;
            acc_seen_q <= 1'b0;
        end else if (req && !busy) begin
            lim_q      <= limit;
            visits_q   <= '0;
            acc_seen_q <= 1'b0;
        end else if (busy && !done) begin
            if (visits_q != CNT_MAX) visits_q <= visits_q + 1'b1;
            if (acc_valid) acc_seen_q <= 1'b1;
        end
    end

    assign bound = (CNT_W'(lim_q) + 1'b1) * CNT_W'(NUM_FRAMES) + CNT_W'(NUM_FRAMES);

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    victim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(victim));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);

    // R5
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10
    visit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !acc_seen_q) |-> (visits_q <= bound));

endmodule

bind nth_chance_sweeper nth_chance_sweeper_chk #(
    .NUM_FRAMES(NUM_FRAMES),
    .AGE_W     (AGE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .req       (req),
    .limit     (limit),
    .done      (done),
    .busy      (busy),
    .victim    (victim)
);

// File: tb/test_nth_chance_sweeper.sv
`timescale 1ns/1ps
module test_nth_chance_sweeper;

    localparam int NF = 16;
    localparam int AW = 3;
    localparam int IW = $clog2(NF);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [IW-1:0] acc_frame = '0;
    logic          req = 1'b0;
    logic [AW-1:0] limit = '0;
    logic          done;
    logic          busy;
    logic [IW-1:0] victim;

    nth_chance_sweeper #(.NUM_FRAMES(NF), .AGE_W(AW)) i_nth_chance_sweeper (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_frame(acc_frame),
        .req(req), .limit(limit), .done(done), .busy(busy), .victim(victim)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    vic;
        int    busy_cycles;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   busy_cnt = 0;
    int   pops = 0;
    bit   finished = 0;

    bit   m_use [NF];
    int   m_age [NF];
    int   m_hand;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
        end
    endtask

    // monitor: pops expected results as done pulses appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy) busy_cnt++;
            if (done) begin
                chk(busy, "R5", "busy during done", int'(busy), 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(victim) == e.vic, e.tag, "victim", int'(victim), e.vic);
                    chk(busy_cnt == e.busy_cycles, "R5", "busy cycles", busy_cnt, e.busy_cycles);
                end
                busy_cnt = 0;
                pops++;
            end
        end
    end

    // reference model of one search; cv = visit number carrying an access (0: none)
    task automatic model_search(input int n, input int cv, input int cf, output int vic, output int k);
        k = 0;
        forever begin
            int  h;
            bit  hit;
            bit  used;
            k++;
            h    = m_hand;
            hit  = (k == cv);
            used = m_use[h] || (hit && cf == h);
            if (used) begin
                m_age[h] = 0;
                m_use[h] = hit && (cf == h);
                m_hand   = (h + 1) % NF;
            end else if (m_age[h] < n) begin
                m_age[h]++;
                m_hand = (h + 1) % NF;
            end else begin
                vic      = h;
                m_age[h] = 0;
                m_use[h] = 0;
                m_hand   = (h + 1) % NF;
            end
            if (hit && cf != h) m_use[cf] = 1'b1;
            if (!used && m_age[h] == 0 && vic == h && m_use[h] == 0 && k > 0 && m_hand == (h + 1) % NF && !(m_age[h] != 0)) begin
                if (!(used) && !(m_age[h] > 0) && (vic == h)) break;
            end
        end
    endtask

    // driver: predicts, pushes, then drives the request
    task automatic do_search(input int n, input int cv, input int cf, input int alt_lim,
                             input bit extra_req, input string tag);
        int   vic;
        int   k;
        int   want;
        exp_t e;
        vic = -1;
        model_search(n, cv, cf, vic, k);
        e.vic = vic;
        e.busy_cycles = k + 1;
        e.tag = tag;
        exp_q.push_back(e);
        want = pops + 1;
        @(negedge clk);
        req   = 1'b1;
        limit = AW'(n);
        @(negedge clk);
        req   = 1'b0;
        limit = AW'(alt_lim);
        for (int j = 1; j <= k; j++) begin
            if (j == cv) begin
                acc_valid = 1'b1;
                acc_frame = IW'(cf);
            end
            if (extra_req && j == 3) req = 1'b1;
            @(negedge clk);
            acc_valid = 1'b0;
            req       = 1'b0;
        end
        @(negedge clk);
        chk(pops == want, tag, "done count", pops, want);
        chk(!busy, "R5", "idle after done", int'(busy), 0);
    endtask

    task automatic touch(input int f);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_frame = IW'(f);
        @(negedge clk);
        acc_valid = 1'b0;
        m_use[f]  = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) begin
            m_use[i] = 1'b0;
            m_age[i] = 0;
        end
        m_hand = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(victim == '0, "R1", "victim after reset", int'(victim), 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_search(0, 0, 0, 0, 1'b0, "R1");          // frame 0, one visit
        do_search(0, 0, 0, 0, 1'b0, "R8");          // next search starts at frame 1
        touch(2);
        touch(3);
        do_search(0, 0, 0, 0, 1'b0, "R2");          // 2 and 3 renewed, 4 taken
        do_search(1, 0, 0, 0, 1'b0, "R3");          // full pass of ageing, then 5
        for (int f = 0; f < NF; f++) touch(f);
        do_search(7, 0, 0, 0, 1'b1, "R10");         // worst case, R6 limit change, R9 stray req
        do_search(0, 1, 7, 0, 1'b0, "R7");          // access on the visited frame wins
        do_search(7, 2, 11, 0, 1'b0, "R7");         // access to a later frame mid-search
        do_search(3, 0, 0, 7, 1'b0, "R4");          // ages above a lowered limit
        for (int r = 0; r < 8; r++) do_search(0, 0, 0, 5, 1'b0, "R6");  // clock mode, wraps
        do_search(2, 0, 0, 0, 1'b0, "R5");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 0);
        chk(!done, "R9", "no late done", int'(done), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule